// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the line and field timing for a 50 Hz raster of 312 lines, each 1024 pixel-clock cycles long (64 µs at 16 MHz). A horizontal cycle counter and a line counter advance on every clock. Fixed comparisons on the two counters decode active-low horizontal and field sync, a display-enable window placed to centre a 640 by 256 picture, and the pixel coordinates within that window for the downstream pixel pipeline.

Field sync is released halfway through a line rather than on a line boundary. A one-cycle frame marker flags the first cycle of each frame. The colour value supplied by the pixel pipeline is passed through inside the window and forced to zero outside it. All timing points are parameters, and the defaults give the 16 MHz raster.

Top module: `raster_sync_gen`

## Requirements
- R1: The horizontal position counts 0 to H_TOTAL-1 (default 1023) and then wraps to 0. On each wrap the line number advances, so `hsync_n` falls exactly once every H_TOTAL cycles.
- R2: The line number counts 0 to V_TOTAL-1 (default 311) and then wraps to 0. `frame_start` is 1 for exactly one cycle per frame, the cycle in which both position and line are 0.
- R3: `hsync_n` is 0 for horizontal positions 0 to HS_END-1 (default 0..74) and 1 for all other positions.
- R4: `vsync_n` is 0 on lines 0 to VS_LINE-1 (default lines 0 and 1). It is also 0 on line VS_LINE at positions below H_TOTAL/2 (default 512). It is 1 at all other times.
- R5: `disp_en` is 1 only when the horizontal position lies in H_ACT_START to H_ACT_START+H_ACT_LEN-1 (default 264..903).
- R6: `disp_en` is 1 only when the line lies in V_ACT_START to V_ACT_START+V_ACT_LEN-1 (default 38..293). R5 and R6 must hold together.
- R7: While `disp_en` is 1, `pix_x` equals position minus H_ACT_START and `pix_y` equals line minus V_ACT_START. While `disp_en` is 0, both are 0.
- R8: `colour_out` equals `colour_in` while `disp_en` is 1 and is 0 otherwise.
- R9: While `rst_n` is 0, and in the first cycle after its release, position and line are 0. In that state `hsync_n` = 0, `vsync_n` = 0, `frame_start` = 1, `disp_en` = 0 and `colour_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| colour_in | input | CW | Pixel colour from the pixel pipeline |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Field sync, active low |
| disp_en | output | 1 | Picture window enable |
| frame_start | output | 1 | One-cycle marker at position 0, line 0 |
| pix_x | output | XW | Column inside the window |
| pix_y | output | YW | Row inside the window |
| colour_out | output | CW | Gated colour |

## Verification
The assertions assume the parameters are ordered consistently: HS_END is below H_TOTAL/2, each window fits inside its total, and VS_LINE lies below V_ACT_START. They also assume `colour_in` may change freely on any cycle. The bench builds a reduced raster that keeps these orderings, so that several whole frames and a mid-frame reset fit in a short run. It changes `colour_in` on every cycle, so gating errors cannot hide behind a constant input.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // True when v lies in the half-open span [lo, lo+len)
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // Field sync active: whole lines before rel_line, then half of rel_line
  function automatic logic field_sync_on(input int unsigned line, input int unsigned pos,
                                         input int unsigned rel_line,
                                         input int unsigned total);
    return (line < rel_line) || ((line == rel_line) && (pos < total / 2));
  endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int H_TOTAL = 1024,
  parameter int HW      = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_pos,
  output logic          line_end
);
  assign line_end = (h_pos == HW'(H_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        h_pos <= '0;
    else if (line_end) h_pos <= '0;
    else               h_pos <= h_pos + 1'b1;
  end

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_pos == '0));
  p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (h_pos == $past(h_pos) + 1'b1));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int V_TOTAL = 312,
  parameter int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  output logic [VW-1:0] v_line
);
  logic frame_end;
  assign frame_end = line_end && (v_line == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         v_line <= '0;
    else if (frame_end) v_line <= '0;
    else if (line_end)  v_line <= v_line + 1'b1;
  end

  p_vwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (v_line == '0));
  p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(v_line));
endmodule

// File: rtl/raster_window.sv
module raster_window
  import raster_pkg::*;
#(
  parameter int H_TOTAL     = 1024,
  parameter int HS_END      = 75,
  parameter int H_ACT_START = 264,
  parameter int H_ACT_LEN   = 640,
  parameter int V_TOTAL     = 312,
  parameter int VS_LINE     = 2,
  parameter int V_ACT_START = 38,
  parameter int V_ACT_LEN   = 256,
  parameter int CW          = 4,
  parameter int HW          = $clog2(H_TOTAL),
  parameter int VW          = $clog2(V_TOTAL),
  parameter int XW          = $clog2(H_ACT_LEN),
  parameter int YW          = $clog2(V_ACT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_line,
  input  logic [CW-1:0] colour_in,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          disp_en,
  output logic          frame_start,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [CW-1:0] colour_out
);
  int unsigned h_i, v_i;
  logic h_win, v_win;

  assign h_i   = 32'(h_pos);
  assign v_i   = 32'(v_line);
  assign h_win = in_span(h_i, H_ACT_START, H_ACT_LEN);
  assign v_win = in_span(v_i, V_ACT_START, V_ACT_LEN);

  assign hsync_n     = !(h_i < HS_END);
  assign vsync_n     = !field_sync_on(v_i, h_i, VS_LINE, H_TOTAL);
  assign disp_en     = h_win && v_win;
  assign frame_start = (h_pos == '0) && (v_line == '0);
  assign pix_x       = disp_en ? XW'(h_i - H_ACT_START) : '0;
  assign pix_y       = disp_en ? YW'(v_i - V_ACT_START) : '0;
  assign colour_out  = disp_en ? colour_in : '0;

  p_hs_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> ($past(h_pos) == HW'(HS_END - 1)));
  p_vs_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (v_line == VW'(VS_LINE) && h_pos == HW'(H_TOTAL / 2)));
  p_fs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!hsync_n && !vsync_n && !disp_en));
  p_x_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(disp_en)) |-> (pix_x == $past(pix_x) + 1'b1));
  p_y_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(disp_en)) |-> $stable(pix_y));
  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && colour_in != '0) |-> (colour_out == '0));
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int H_TOTAL     = 1024,
  parameter int HS_END      = 75,
  parameter int H_ACT_START = 264,
  parameter int H_ACT_LEN   = 640,
  parameter int V_TOTAL     = 312,
  parameter int VS_LINE     = 2,
  parameter int V_ACT_START = 38,
  parameter int V_ACT_LEN   = 256,
  parameter int CW          = 4,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int XW = $clog2(H_ACT_LEN),
  localparam int YW = $clog2(V_ACT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] colour_in,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          disp_en,
  output logic          frame_start,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [CW-1:0] colour_out
);
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_line;
  logic          line_end;

  raster_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_end(line_end));

  raster_vcount #(.V_TOTAL(V_TOTAL), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .v_line(v_line));

  raster_window #(
    .H_TOTAL(H_TOTAL), .HS_END(HS_END), .H_ACT_START(H_ACT_START),
    .H_ACT_LEN(H_ACT_LEN), .V_TOTAL(V_TOTAL), .VS_LINE(VS_LINE),
    .V_ACT_START(V_ACT_START), .V_ACT_LEN(V_ACT_LEN), .CW(CW),
    .HW(HW), .VW(VW), .XW(XW), .YW(YW)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_line(v_line),
    .colour_in(colour_in), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_en(disp_en), .frame_start(frame_start), .pix_x(pix_x),
    .pix_y(pix_y), .colour_out(colour_out));

  // R1: a line wrap always lands on position 0 of hsync low
  p_line_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !hsync_n);
endmodule

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;
  localparam int HT = 64, HSE = 5, HAS = 16, HAL = 40;
  localparam int VT = 20, VSL = 2, VAS = 4, VAL = 12, CW = 4;
  localparam int XW = $clog2(HAL), YW = $clog2(VAL);

  typedef struct {
    bit rst; logic hs, vs, de, fs;
    logic [XW-1:0] x; logic [YW-1:0] y; logic [CW-1:0] col;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] colour_in = '0;
  logic hsync_n, vsync_n, disp_en, frame_start;
  logic [XW-1:0] pix_x; logic [YW-1:0] pix_y; logic [CW-1:0] colour_out;

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  exp_t q[$];
  event ev_chk;

  always #4 clk = ~clk;

  raster_sync_gen #(.H_TOTAL(HT), .HS_END(HSE), .H_ACT_START(HAS), .H_ACT_LEN(HAL),
    .V_TOTAL(VT), .VS_LINE(VSL), .V_ACT_START(VAS), .V_ACT_LEN(VAL), .CW(CW))
  u_raster_sync_gen (.clk(clk), .rst_n(rst_n), .colour_in(colour_in),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
    .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y),
    .colour_out(colour_out));

  // Reference: state after k clocks since release is a plain division
  function automatic exp_t model(int k, logic [CW-1:0] col, bit r);
    exp_t e; int h, v; bit win;
    h = k % HT; v = (k / HT) % VT;
    win = (h >= HAS) && (h < HAS + HAL) && (v >= VAS) && (v < VAS + VAL);
    e.rst = r;
    e.hs  = (h >= HSE);
    e.vs  = !((v < VSL) || (v == VSL && h < HT / 2));
    e.de  = win;
    e.fs  = (h == 0 && v == 0);
    e.x   = win ? XW'(h - HAS) : '0;
    e.y   = win ? YW'(v - VAS) : '0;
    e.col = win ? col : '0;
    return e;
  endfunction

  task automatic cmp(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s at n=%0d: actual %0d expected %0d", tag, what, n, act, expv);
    end
  endtask

  // Monitor
  always @(ev_chk) begin
    exp_t e;
    #1;
    e = q.pop_front();
    cmp(e.rst ? "R9" : "R1,R3", "hsync_n", hsync_n, e.hs);
    cmp(e.rst ? "R9" : "R4", "vsync_n", vsync_n, e.vs);
    cmp(e.rst ? "R9" : "R5,R6", "disp_en", disp_en, e.de);
    cmp(e.rst ? "R9" : "R2", "frame_start", frame_start, e.fs);
    cmp("R7", "pix_x", pix_x, e.x);
    cmp("R7", "pix_y", pix_y, e.y);
    cmp(e.rst ? "R9" : "R8", "colour_out", colour_out, e.col);
  end

  task automatic push(bit r);
    colour_in = CW'(n * 7 + 3);
    q.push_back(model(n, colour_in, r));
    -> ev_chk;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    n = 0;
    push(1);          // R9: state while held in reset
    #2 rst_n = 1;
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n++;
      push(0);
    end
  endtask

  initial begin
    do_reset();
    run(HT * VT + HT * VT / 2);   // R2: wrap through a full frame, stop mid-frame
    do_reset();                   // R9: reset from mid-frame
    run(2 * HT * VT + 10);
    @(negedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule